// File: doc/BRIEF.md
# Packed SIMD Shift Unit

This block shifts every lane of a 32-bit packed operand by a common amount. The operand is split into two 16-bit lanes or four 8-bit lanes, and each lane is shifted separately. The block does arithmetic right shifts, logical right shifts and logical left shifts. It also has a bidirectional shift whose signed amount chooses the direction. The amount comes from the low bits of a register operand or from an immediate field.

A two-bit mode field changes the plain shifts. In mode 01, right shifts round the result and left shifts saturate. The bidirectional shift always saturates when it shifts left, and in mode 01 it rounds when it shifts right.

There is no state machine. The block is combinational lane logic followed by one register stage that holds the result, an output valid bit and a sticky saturation flag. A request is accepted on any cycle in which `in_valid` is high, and its result appears one cycle later.

Top module: `simd_shift_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `out_valid`, `result` and `sat_flag` are all zero until a request arrives.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. In a cycle after `in_valid` was low, `result` keeps its previous value.
- R3: With `lane8`=0 the operand is two independent 16-bit lanes, and a plain shift uses amount bits [3:0]. With `lane8`=1 it is four independent 8-bit lanes, and a plain shift uses amount bits [2:0].
- R4: With `use_imm`=1 the amount is `shamt_imm`. With `use_imm`=0 the amount is `shamt_reg`.
- R5: The `op` encoding is 00 = arithmetic right, 01 = logical right, 10 = logical left and 11 = bidirectional. With mode 00 the plain shifts truncate.
- R6: With mode 01, both right shifts add the last bit shifted out to the truncated lane result, which rounds half up.
- R7: With mode 01, a logical left shift treats each lane as signed. A lane that overflows is clamped to the most positive or most negative lane value, according to the lane's original sign.
- R8: The bidirectional op reads a signed amount: 5 bits for 16-bit lanes and 4 bits for 8-bit lanes. A non-negative amount gives a saturating left shift. A negative amount gives an arithmetic right shift by its magnitude, and the most negative code shifts by the full lane width. In mode 01 that right shift rounds as in R6.
- R9: `sat_flag` goes high in the cycle after a request in which any lane saturated. It then stays high until reset.
- R10: A shift amount of zero returns the operand unchanged in every op and mode.
- R11: Modes 10 and 11 act like mode 00. The bidirectional left shift still saturates in these modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Shift operation code |
| lane8 | input | 1 | 1 = four 8-bit lanes, 0 = two 16-bit lanes |
| mode | input | 2 | 01 = round right / saturate left |
| operand | input | 32 | Packed data to shift |
| shamt_reg | input | 5 | Amount taken from a register operand |
| shamt_imm | input | 5 | Amount taken from an immediate |
| use_imm | input | 1 | Selects the immediate amount |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Registered packed result |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The only internal state is the result register, the valid bit and the sticky flag, so every fault appears at the ports in the cycle after the request that caused it. A wrong lane-amount slice or a wrong rounding bit shows as a corrupted lane value one cycle later. A saturation detector that fires when it should not, or a flag that does not hold, shows on `sat_flag` one cycle later. The tests reset before each vector, so every saturation case is judged on its own. A held-result check and a sticky-hold check catch stale or lost state one cycle after an idle cycle.

// File: rtl/simd_shift_pkg.sv
`timescale 1ns/1ps
package simd_shift_pkg;
    typedef enum logic [1:0] {
        OP_SRA   = 2'b00,
        OP_SRL   = 2'b01,
        OP_SLL   = 2'b10,
        OP_BIDIR = 2'b11
    } shift_op_e;

    localparam logic [1:0] MODE_ADJUST = 2'b01;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned AMT_W  = 5;
endpackage

// File: rtl/simd_shift_lane.sv
`timescale 1ns/1ps
module simd_shift_lane
    import simd_shift_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]          x,
    input  logic [$clog2(W):0]    amt,
    input  shift_op_e             op,
    input  logic [1:0]            mode,
    output logic [W-1:0]          y,
    output logic                  sat
);
    localparam int unsigned AW = $clog2(W);

    logic                 neg;
    logic [AW:0]          mag;
    logic [AW:0]          s;
    logic                 left;
    logic                 arith;
    logic                 rnd_en;
    logic                 sat_en;
    logic [W+1:0]         rext;
    logic signed [W+1:0]  rsh;
    logic [W-1:0]         rres;
    logic [2*W-1:0]       lwide;
    logic [W:0]           lhigh;
    logic                 ovf;
    logic [W-1:0]         lres;

    always_comb begin
        neg = amt[AW];
        mag = ~amt + 1'b1;
        if (op == OP_BIDIR) begin
            left = !neg;
            s    = neg ? mag : {1'b0, amt[AW-1:0]};
        end else begin
            left = (op == OP_SLL);
            s    = {1'b0, amt[AW-1:0]};
        end
        arith  = (op == OP_SRA) || (op == OP_BIDIR);
        rnd_en = (mode == MODE_ADJUST) && !left;
        sat_en = left && ((mode == MODE_ADJUST) || (op == OP_BIDIR));

        // right path: one guard bit below the lane captures the last bit out
        rext = {arith & x[W-1], x, 1'b0};
        rsh  = $signed(rext) >>> s;
        rres = rsh[W:1] + {{(W-1){1'b0}}, rnd_en & rsh[0]};

        // left path: sign-extended double-width shift exposes overflow
        lwide = {{W{x[W-1]}}, x} << s[AW-1:0];
        lhigh = lwide[2*W-1:W-1];
        ovf   = !((&lhigh) || !(|lhigh));
        if (sat_en && ovf)
            lres = x[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else
            lres = lwide[W-1:0];

        y   = left ? lres : rres;
        sat = left && sat_en && ovf;
    end

    // R10: zero amount is an identity in every op and mode
    always_comb begin
        if (s == '0) begin
            assert_zero_identity_R10: assert (y == x);
        end
    end
endmodule

// File: rtl/simd_shift_bank.sv
`timescale 1ns/1ps
module simd_shift_bank
    import simd_shift_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [DATA_W-1:0]     operand,
    input  logic [$clog2(W):0]    amt,
    input  shift_op_e             op,
    input  logic [1:0]            mode,
    output logic [DATA_W-1:0]     res,
    output logic                  sat_any
);
    localparam int unsigned LANES = DATA_W / W;

    logic [LANES-1:0] lane_sat;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        simd_shift_lane #(.W(W)) i_lane (
            .x    (operand[g*W +: W]),
            .amt  (amt),
            .op   (op),
            .mode (mode),
            .y    (res[g*W +: W]),
            .sat  (lane_sat[g])
        );
    end

    assign sat_any = |lane_sat;
endmodule

// File: rtl/simd_shift_unit.sv
`timescale 1ns/1ps
module simd_shift_unit
    import simd_shift_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  op,
    input  logic        lane8,
    input  logic [1:0]  mode,
    input  logic [31:0] operand,
    input  logic [4:0]  shamt_reg,
    input  logic [4:0]  shamt_imm,
    input  logic        use_imm,
    output logic        out_valid,
    output logic [31:0] result,
    output logic        sat_flag
);
    localparam int unsigned W_WIDE   = 16;
    localparam int unsigned W_NARROW = 8;
    localparam int unsigned AW_WIDE   = $clog2(W_WIDE);
    localparam int unsigned AW_NARROW = $clog2(W_NARROW);

    shift_op_e         op_q;
    logic [AMT_W-1:0]  amt_sel;
    logic [DATA_W-1:0] res_wide;
    logic [DATA_W-1:0] res_narrow;
    logic              sat_wide;
    logic              sat_narrow;
    logic [DATA_W-1:0] res_next;
    logic              sat_next;

    always_comb begin
        op_q     = shift_op_e'(op);
        amt_sel  = use_imm ? shamt_imm : shamt_reg;
        res_next = lane8 ? res_narrow : res_wide;
        sat_next = lane8 ? sat_narrow : sat_wide;
    end

    simd_shift_bank #(.W(W_WIDE)) i_bank_wide (
        .operand (operand),
        .amt     (amt_sel[AW_WIDE:0]),
        .op      (op_q),
        .mode    (mode),
        .res     (res_wide),
        .sat_any (sat_wide)
    );

    simd_shift_bank #(.W(W_NARROW)) i_bank_narrow (
        .operand (operand),
        .amt     (amt_sel[AW_NARROW:0]),
        .op      (op_q),
        .mode    (mode),
        .res     (res_narrow),
        .sat_any (sat_narrow)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_next;
                if (sat_next)
                    sat_flag <= 1'b1;
            end
        end
    end

    assert_valid_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));
    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag |=> sat_flag);
    assert_sticky_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> $past(in_valid));
endmodule

// File: tb/test_simd_shift_unit.sv
`timescale 1ns/1ps
module test_simd_shift_unit;
    typedef struct packed {
        logic [23:0] tag;
        logic [1:0]  op;
        logic        l8;
        logic [1:0]  mode;
        logic        uimm;
        logic [4:0]  imm;
        logic [31:0] a;
        logic [4:0]  reg_amt;
        logic [31:0] exp;
        logic        sat;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{"R5 ", 2'd0, 1'b0, 2'b00, 1'b0, 5'd0, 32'h80007FF0, 5'd4,  32'hF80007FF, 1'b0},
        '{"R5 ", 2'd1, 1'b0, 2'b00, 1'b0, 5'd0, 32'h800000F0, 5'd4,  32'h0800000F, 1'b0},
        '{"R5 ", 2'd2, 1'b0, 2'b00, 1'b0, 5'd0, 32'h12348001, 5'd4,  32'h23400010, 1'b0},
        '{"R6 ", 2'd0, 1'b0, 2'b01, 1'b0, 5'd0, 32'hFFF80018, 5'd4,  32'h00000002, 1'b0},
        '{"R4 ", 2'd1, 1'b0, 2'b01, 1'b1, 5'd1, 32'hFFFF0007, 5'h1F, 32'h80000004, 1'b0},
        '{"R7 ", 2'd2, 1'b0, 2'b01, 1'b0, 5'd0, 32'h4000C000, 5'd1,  32'h7FFF8000, 1'b1},
        '{"R7 ", 2'd2, 1'b0, 2'b01, 1'b0, 5'd0, 32'h0001A000, 5'd2,  32'h00048000, 1'b1},
        '{"R3 ", 2'd0, 1'b1, 2'b00, 1'b0, 5'd0, 32'h807FF010, 5'h0B, 32'hF00FFE02, 1'b0},
        '{"R7 ", 2'd2, 1'b1, 2'b01, 1'b0, 5'd0, 32'h20E003C0, 5'd2,  32'h7F800C80, 1'b1},
        '{"R8 ", 2'd3, 1'b0, 2'b00, 1'b0, 5'd0, 32'h0100FF00, 5'd7,  32'h7FFF8000, 1'b1},
        '{"R8 ", 2'd3, 1'b0, 2'b00, 1'b0, 5'd0, 32'h80000018, 5'h1C, 32'hF8000001, 1'b0},
        '{"R8 ", 2'd3, 1'b0, 2'b01, 1'b0, 5'd0, 32'h80000018, 5'h1C, 32'hF8000002, 1'b0},
        '{"R8 ", 2'd3, 1'b0, 2'b00, 1'b0, 5'd0, 32'h80017FFF, 5'h10, 32'hFFFF0000, 1'b0},
        '{"R8 ", 2'd3, 1'b1, 2'b00, 1'b0, 5'd0, 32'h807FC001, 5'h08, 32'hFF00FF00, 1'b0},
        '{"R10", 2'd2, 1'b0, 2'b01, 1'b0, 5'd0, 32'h80007FFF, 5'd0,  32'h80007FFF, 1'b0},
        '{"R10", 2'd0, 1'b0, 2'b01, 1'b0, 5'd0, 32'h12348765, 5'd0,  32'h12348765, 1'b0},
        '{"R11", 2'd0, 1'b0, 2'b10, 1'b0, 5'd0, 32'hFFF80018, 5'd4,  32'hFFFF0001, 1'b0},
        '{"R11", 2'd2, 1'b0, 2'b11, 1'b0, 5'd0, 32'h40000001, 5'd1,  32'h80000002, 1'b0},
        '{"R4 ", 2'd1, 1'b0, 2'b00, 1'b0, 5'd8, 32'hAB0000CD, 5'd4,  32'h0AB0000C, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = '0;
    logic        lane8 = 1'b0;
    logic [1:0]  mode = '0;
    logic [31:0] operand = '0;
    logic [4:0]  shamt_reg = '0;
    logic [4:0]  shamt_imm = '0;
    logic        use_imm = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        sat_flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    simd_shift_unit i_simd_shift_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane8(lane8),
        .mode(mode), .operand(operand), .shamt_reg(shamt_reg), .shamt_imm(shamt_imm),
        .use_imm(use_imm), .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        op = v.op; lane8 = v.l8; mode = v.mode; use_imm = v.uimm;
        shamt_imm = v.imm; shamt_reg = v.reg_amt; operand = v.a;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 valid", {31'd0, out_valid}, 32'd0);
        chk("R1 result", result, 32'd0);
        chk("R1 flag", {31'd0, sat_flag}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            drive(VECS[i]);
            chk($sformatf("%s vec%0d result", VECS[i].tag, i), result, VECS[i].exp);
            chk($sformatf("%s vec%0d sat", VECS[i].tag, i), {31'd0, sat_flag}, {31'd0, VECS[i].sat});
        end

        // R2: valid follows request, result held while idle
        do_reset();
        drive(VECS[0]);
        chk("R2 valid high", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        chk("R2 valid low", {31'd0, out_valid}, 32'd0);
        operand = 32'h5555AAAA;
        @(negedge clk);
        chk("R2 result held", result, VECS[0].exp);

        // R9: sticky flag survives later non-saturating requests, reset clears
        do_reset();
        drive(VECS[5]);
        drive(VECS[1]);
        chk("R9 result after", result, VECS[1].exp);
        chk("R9 flag held", {31'd0, sat_flag}, 32'd1);
        do_reset();
        chk("R9 flag cleared", {31'd0, sat_flag}, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule